// File: doc/BRIEF.md
# Timer and counter CSR access checker

This block is a purely combinational permission filter for a hart with hypervisor support. It watches one CSR access at a time, described by the current privilege mode and the 12-bit CSR number. It decides whether the access must trap with an illegal-instruction exception or with a virtual-instruction exception. The covered CSRs are the supervisor timer-compare register (0x14D), the guest timer-compare register (0x24D) and the 64 user-level counter numbers (0xC00–0xC1F and their upper halves 0xC80–0xC9F).

The verdict depends on two sets of enables: the machine and hypervisor counter-enable words, and the machine and hypervisor timer-compare enables from the environment configuration. A denial by a machine-level enable is an illegal-instruction fault. A denial by a hypervisor-level enable, while running virtualized, is a virtual-instruction fault. The surrounding CSR unit merges these flags with its other permission checks. Counter storage and timer interrupt generation sit elsewhere.

Top module: `csr_tcnt_check`

## Requirements
- R1: With mode_i = 0 (M), neither flag is ever raised.
- R2: In any mode other than M (HS=1, HU=2, VS=3, VU=4), an access to 0x14D or 0x24D raises illegal_o when menv_stce_i is 0.
- R3: In any mode other than M, an access to 0x14D or 0x24D raises illegal_o when bit 1 (TM) of mcounteren_i is 0.
- R4: In VS mode, an access to 0x14D that R2/R3 allow raises virtual_o when bit 1 of hcounteren_i is 0 or henv_stce_i is 0; it raises no flag when both are 1.
- R5: In VS or VU mode, an access to 0x24D that R2/R3 allow raises virtual_o exactly when henv_stce_i is 0; bit 1 of hcounteren_i has no effect on it.
- R6: In HS and HU modes, no timer-compare access raises virtual_o, whatever the hypervisor enables hold; in VU mode an access to 0x14D raises virtual_o never.
- R7: In any mode other than M, an access to counter address 0xC00+x or 0xC80+x (x = address bits 4:0) raises illegal_o when bit x of mcounteren_i is 0, and no flag in HS/HU when it is 1.
- R8: In VS or VU mode, a counter access with bit x of mcounteren_i set raises virtual_o exactly when bit x of hcounteren_i is 0.
- R9: illegal_o and virtual_o are never 1 together; an illegal-instruction condition suppresses the virtual one.
- R10: An access to any CSR number outside 0x14D, 0x24D, 0xC00–0xC1F and 0xC80–0xC9F raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Privilege mode: 0=M, 1=HS, 2=HU, 3=VS, 4=VU |
| csr_addr_i | input | 12 | CSR number being accessed |
| mcounteren_i | input | 32 | Machine counter-enable word |
| hcounteren_i | input | 32 | Hypervisor counter-enable word |
| menv_stce_i | input | 1 | Machine timer-compare enable |
| henv_stce_i | input | 1 | Hypervisor timer-compare enable |
| illegal_o | output | 1 | Access raises an illegal-instruction exception |
| virtual_o | output | 1 | Access raises a virtual-instruction exception |

## Verification
The assertions assume that mode_i carries one of the five defined codes 0 to 4 and that every input is at a known value whenever it is evaluated. The codes 5 to 7 have no defined meaning, so the bench sweeps only the five legal modes. It starts every input at zero so that nothing is unknown at time zero. Within each mode it runs every covered CSR number and a few neighbours outside the covered set against all sixteen combinations of the four relevant enable bits. Fixed distractor patterns fill the counter-enable bits that do not matter, so a check picking the wrong bit shows up.

// File: rtl/csr_tcnt_pkg.sv
package csr_tcnt_pkg;
  typedef enum logic [2:0] {
    PRV_M  = 3'd0,
    PRV_HS = 3'd1,
    PRV_HU = 3'd2,
    PRV_VS = 3'd3,
    PRV_VU = 3'd4
  } priv_e;

  typedef struct packed {
    logic below_m;
    logic virt;
    logic vs;
  } mode_cls_t;

  function automatic mode_cls_t classify(priv_e m);
    mode_cls_t c;
    c.below_m = (m != PRV_M);
    c.virt    = (m == PRV_VS) || (m == PRV_VU);
    c.vs      = (m == PRV_VS);
    return c;
  endfunction
endpackage

// File: rtl/csr_tcnt_decode.sv
module csr_tcnt_decode #(
  parameter int          ADDR_W       = 12,
  parameter int          CNT_N        = 32,
  parameter logic [11:0] STCMP_ADDR   = 12'h14D,
  parameter logic [11:0] VSTCMP_ADDR  = 12'h24D,
  parameter logic [11:0] CNT_LO_BASE  = 12'hC00,
  parameter logic [11:0] CNT_HI_BASE  = 12'hC80,
  localparam int         IDX_W        = $clog2(CNT_N)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              stcmp_o,
  output logic              vstcmp_o,
  output logic              cnt_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic lo_hit, hi_hit;

  always_comb begin
    stcmp_o  = (addr_i == STCMP_ADDR[ADDR_W-1:0]);
    vstcmp_o = (addr_i == VSTCMP_ADDR[ADDR_W-1:0]);
    lo_hit   = (addr_i[ADDR_W-1:IDX_W] == CNT_LO_BASE[ADDR_W-1:IDX_W]);
    hi_hit   = (addr_i[ADDR_W-1:IDX_W] == CNT_HI_BASE[ADDR_W-1:IDX_W]);
    cnt_o    = lo_hit || hi_hit;
    idx_o    = addr_i[IDX_W-1:0];
  end
endmodule

// File: rtl/csr_tcnt_timer_rule.sv
module csr_tcnt_timer_rule
  import csr_tcnt_pkg::*;
(
  input  mode_cls_t cls_i,
  input  logic      stcmp_i,
  input  logic      vstcmp_i,
  input  logic      m_tm_i,
  input  logic      h_tm_i,
  input  logic      m_stce_i,
  input  logic      h_stce_i,
  output logic      ii_o,
  output logic      vi_o
);
  logic hit, h_stce_deny, h_tm_deny;

  always_comb begin
    hit         = stcmp_i || vstcmp_i;
    h_stce_deny = m_stce_i && !h_stce_i;
    h_tm_deny   = m_tm_i && !h_tm_i;
    ii_o        = hit && cls_i.below_m && (!m_tm_i || !m_stce_i);
    // guest timer-compare ignores hypervisor TM; host one in VS sees both
    vi_o        = (stcmp_i && cls_i.vs && (h_tm_deny || h_stce_deny))
               || (vstcmp_i && cls_i.virt && h_stce_deny);
  end

  always_comb begin
    AST_TMR_STCE_GATE: assert (!(hit && cls_i.below_m && !m_stce_i) || ii_o)
      else $error("stce gate"); // R2
    AST_TMR_TM_GATE: assert (!(hit && cls_i.below_m && !m_tm_i) || ii_o)
      else $error("tm gate"); // R3
  end
endmodule

// File: rtl/csr_tcnt_cnt_rule.sv
module csr_tcnt_cnt_rule
  import csr_tcnt_pkg::*;
#(
  parameter int  CNT_N = 32,
  localparam int IDX_W = $clog2(CNT_N)
) (
  input  mode_cls_t        cls_i,
  input  logic             cnt_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_N-1:0] m_en_i,
  input  logic [CNT_N-1:0] h_en_i,
  output logic             ii_o,
  output logic             vi_o
);
  logic m_bit, h_bit;

  always_comb begin
    m_bit = m_en_i[idx_i];
    h_bit = h_en_i[idx_i];
    ii_o  = cnt_i && cls_i.below_m && !m_bit;
    vi_o  = cnt_i && cls_i.virt && !h_bit;
  end

  always_comb begin
    AST_CNT_HOST_NO_VI: assert (cls_i.virt || !vi_o)
      else $error("counter vi outside guest"); // R8
  end
endmodule

// File: rtl/csr_tcnt_check.sv
module csr_tcnt_check
  import csr_tcnt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_N  = 32,
  parameter int TM_BIT = 1
) (
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [CNT_N-1:0]  mcounteren_i,
  input  logic [CNT_N-1:0]  hcounteren_i,
  input  logic              menv_stce_i,
  input  logic              henv_stce_i,
  output logic              illegal_o,
  output logic              virtual_o
);
  localparam int IDX_W = $clog2(CNT_N);

  mode_cls_t        cls;
  logic             stcmp, vstcmp, cnt;
  logic [IDX_W-1:0] idx;
  logic             t_ii, t_vi, c_ii, c_vi;

  assign cls = classify(priv_e'(mode_i));

  csr_tcnt_decode #(.ADDR_W(ADDR_W), .CNT_N(CNT_N)) u_dec (
    .addr_i   (csr_addr_i),
    .stcmp_o  (stcmp),
    .vstcmp_o (vstcmp),
    .cnt_o    (cnt),
    .idx_o    (idx)
  );

  csr_tcnt_timer_rule u_tmr (
    .cls_i    (cls),
    .stcmp_i  (stcmp),
    .vstcmp_i (vstcmp),
    .m_tm_i   (mcounteren_i[TM_BIT]),
    .h_tm_i   (hcounteren_i[TM_BIT]),
    .m_stce_i (menv_stce_i),
    .h_stce_i (henv_stce_i),
    .ii_o     (t_ii),
    .vi_o     (t_vi)
  );

  csr_tcnt_cnt_rule #(.CNT_N(CNT_N)) u_cnt (
    .cls_i  (cls),
    .cnt_i  (cnt),
    .idx_i  (idx),
    .m_en_i (mcounteren_i),
    .h_en_i (hcounteren_i),
    .ii_o   (c_ii),
    .vi_o   (c_vi)
  );

  // machine-level denial wins over hypervisor-level denial
  always_comb begin
    illegal_o = t_ii || c_ii;
    virtual_o = (t_vi || c_vi) && !illegal_o;
  end

  always_comb begin
    AST_M_QUIET: assert (cls.below_m || (!illegal_o && !virtual_o))
      else $error("flag in M mode"); // R1
    AST_HOST_NO_TMR_VI: assert (cls.virt || !(stcmp || vstcmp) || !virtual_o)
      else $error("timer vi outside guest"); // R6
    AST_ONE_HOT: assert ($onehot0({illegal_o, virtual_o}))
      else $error("both flags"); // R9
    AST_OTHER_QUIET: assert (stcmp || vstcmp || cnt || (!illegal_o && !virtual_o))
      else $error("flag on uncovered CSR"); // R10
  end
endmodule

// File: tb/csr_tcnt_check_bench.sv
`timescale 1ns/1ps
module csr_tcnt_check_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [11:0] addr = 12'h000;
  logic [31:0] mc = 32'h0;
  logic [31:0] hc = 32'h0;
  logic        ms = 1'b0;
  logic        hs = 1'b0;
  logic        ii, vi;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  csr_tcnt_check u_csr_tcnt_check (
    .mode_i       (mode),
    .csr_addr_i   (addr),
    .mcounteren_i (mc),
    .hcounteren_i (hc),
    .menv_stce_i  (ms),
    .henv_stce_i  (hs),
    .illegal_o    (ii),
    .virtual_o    (vi)
  );

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s mode=%0d addr=%h mc=%h hc=%h ms=%b hs=%b act{ii,vi}=%b exp=%b",
               tag, mode, addr, mc, hc, ms, hs, act, exp);
    end
  endtask

  // expected verdict from the requirements
  task automatic expect_of(output logic e_ii, output logic e_vi, output string tag);
    bit lower, virt, st, vst, cn;
    int x;
    lower = (mode != 3'd0);
    virt  = (mode == 3'd3) || (mode == 3'd4);
    st    = (addr == 12'h14D);
    vst   = (addr == 12'h24D);
    cn    = (addr[11:5] == 7'h60) || (addr[11:5] == 7'h64);
    x     = int'(addr[4:0]);
    e_ii = 1'b0; e_vi = 1'b0;
    if (!lower) tag = "R1";
    else if (st || vst) begin
      e_ii = !ms || !mc[1];
      if (st && mode == 3'd3) e_vi = (mc[1] && !hc[1]) || (ms && !hs);
      if (vst && virt) e_vi = ms && !hs;
      if (!ms) tag = "R2";
      else if (!mc[1]) tag = "R3";
      else if (st && mode == 3'd3) tag = "R4";
      else if (vst && virt) tag = "R5";
      else tag = "R6";
    end else if (cn) begin
      e_ii = !mc[x];
      if (virt) e_vi = mc[x] && !hc[x];
      tag = (virt && mc[x]) ? "R8" : "R7";
    end else tag = "R10";
    if (e_ii) e_vi = 1'b0;
  endtask

  task automatic run_vec(logic [2:0] m, logic [11:0] a, int c);
    logic e_ii, e_vi;
    string tag;
    int rel;
    @(posedge clk);
    rel  = ((a[11:5] == 7'h60) || (a[11:5] == 7'h64)) ? int'(a[4:0]) : 1;
    mode = m;
    addr = a;
    mc   = 32'h5A3C_96E1;
    hc   = 32'hC3A5_0F69;
    mc[rel] = c[0];
    hc[rel] = c[1];
    ms   = c[2];
    hs   = c[3];
    #1;
    expect_of(e_ii, e_vi, tag);
    check(tag, {ii, vi}, {e_ii, e_vi});
    check("R9", {1'b0, ii && vi}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1", {ii, vi}, 2'b00); // all-zero inputs, M mode
    for (int m = 0; m < 5; m++) begin
      for (int c = 0; c < 16; c++) begin
        run_vec(3'(m), 12'h14D, c);
        run_vec(3'(m), 12'h24D, c);
        for (int k = 0; k < 32; k++) begin
          run_vec(3'(m), 12'hC00 + 12'(k), c);
          run_vec(3'(m), 12'hC80 + 12'(k), c);
        end
        // R10 neighbours
        run_vec(3'(m), 12'h14C, c);
        run_vec(3'(m), 12'hC20, c);
        run_vec(3'(m), 12'hCA0, c);
        run_vec(3'(m), 12'hB01, c);
      end
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    #10;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule